// File: doc/BRIEF.md
# Multi-mode Reed-Solomon systematic encoder

This block turns a stream of 4-bit message symbols into systematic Reed-Solomon codewords. A 2-bit mode input selects one of three codes, and one datapath serves all three: a short code of length 7 with 3 message symbols over GF(8), and two codes of length 15 over GF(16) with 11 or 9 message symbols. The block accepts one symbol per clock. Each message symbol goes straight to the output in the same cycle and also enters a six-stage remainder register that divides by the code's generator polynomial. After the last message symbol, the remainder register stops taking feedback and shifts its parity symbols out, highest-order symbol first.

In the two codes with four parity symbols, the upper two remainder stages are frozen, and the feedback is taken from the fourth stage. The field multipliers reduce modulo x^3+x+1 in the GF(8) mode and modulo x^4+x+1 in the GF(16) modes. A position counter wraps at the end of each codeword, so codewords follow one another with no gap. Selecting mode zero parks the block: the output is zero and the counter and remainder are cleared. The mode is expected to change only at a codeword boundary or through the parked mode.

Top module: `rs_multi_encoder`

## Requirements
- R1: sel=01 gives codewords of 7 symbols with 3 message symbols, sel=10 gives 15 symbols with 11 message symbols, and sel=11 gives 15 symbols with 9 message symbols.
- R2: For the first k cycles of a codeword, sym_out equals sym_in in the same cycle (with bit 3 masked in the 7-symbol mode).
- R3: With sel=01, the parity is the remainder of m(x)x^4 divided by x^4 + a^3x^3 + x^2 + a x + a^3 over GF(8) (a is a root of x^3+x+1). The message 0,1,2 gives parity 2,3,1,3.
- R4: With sel=10, the parity is the remainder of m(x)x^4 divided by x^4 + a^13x^3 + a^6x^2 + a^3x + a^10 over GF(16) (a is a root of x^4+x+1). The message 0,1,...,A gives parity C,E,8,3. Only the four lower remainder stages change.
- R5: With sel=11, the parity is the remainder of m(x)x^6 divided by x^6 + a^10x^5 + a^14x^4 + a^4x^3 + a^6x^2 + a^9x + a^6 over GF(16). The message 0,...,8 gives parity B,C,0,5,7,8.
- R6: Parity symbols appear highest-order coefficient first, and sym_in is ignored while they appear. The next codeword starts in the cycle right after the last parity symbol.
- R7: With sel=01, bit 3 of sym_in is ignored and bit 3 of sym_out is always 0.
- R8: sel=00 forces sym_out to 0 and clears the codeword position and the remainder. Selecting a code afterwards starts a fresh codeword.
- R9: Asserting rst_n low clears the block at once and forces sym_out to 0. After rst_n rises, the block stays in reset through two rising clock edges, and the first message symbol is taken in the cycle after the second edge.
- R10: After the last parity symbol of a codeword, every remainder stage is zero, so one codeword does not affect the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 2 | Code select: 00 parked, 01 length 7, 10 length 15 with 4 parity, 11 length 15 with 6 parity |
| sym_in | input | 4 | Message symbol, one per clock |
| sym_out | output | 4 | Codeword symbol: message, then parity |

## Verification
Each mode is driven first with its known counting message, whose parity is fixed. This catches a wrong generator coefficient, a wrong tap point or a wrong field. Random messages then run back to back against a polynomial long division in the bench, which exposes state carried between codewords and errors in the order in which parity leaves. In the 7-symbol mode the random symbols keep bit 3 set, to show that the bit is masked. During parity the input is held at all ones, which separates a correct feedback cut-off from one that leaks. Parking mid-word and resetting mid-word, each followed by a known codeword, show that both paths clear the partial remainder.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W    = 4;
  localparam int MAX_N    = (1 << SYM_W) - 1;
  localparam int CNT_W    = $clog2(MAX_N + 1);
  localparam int NSTAGE   = 6;
  localparam int NSHORT   = 4;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_7_3   = 2'b01,
    MODE_15_11 = 2'b10,
    MODE_15_9  = 2'b11
  } rs_mode_e;

  function automatic logic [CNT_W-1:0] code_len(rs_mode_e m);
    case (m)
      MODE_7_3:   code_len = CNT_W'(7);
      MODE_15_11: code_len = CNT_W'(15);
      MODE_15_9:  code_len = CNT_W'(15);
      default:    code_len = CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] msg_len(rs_mode_e m);
    case (m)
      MODE_7_3:   msg_len = CNT_W'(3);
      MODE_15_11: msg_len = CNT_W'(11);
      MODE_15_9:  msg_len = CNT_W'(9);
      default:    msg_len = CNT_W'(0);
    endcase
  endfunction

  // Generator coefficients g_idx, field elements in polynomial basis.
  function automatic logic [SYM_W-1:0] gen_coef(rs_mode_e m, int idx);
    logic [SYM_W-1:0] c;
    c = '0;
    case (m)
      MODE_7_3: case (idx)
        0: c = 4'h3; 1: c = 4'h2; 2: c = 4'h1; 3: c = 4'h3;
        default: c = '0;
      endcase
      MODE_15_11: case (idx)
        0: c = 4'h7; 1: c = 4'h8; 2: c = 4'hC; 3: c = 4'hD;
        default: c = '0;
      endcase
      MODE_15_9: case (idx)
        0: c = 4'hC; 1: c = 4'hA; 2: c = 4'hC; 3: c = 4'h3;
        4: c = 4'h9; 5: c = 4'h7;
        default: c = '0;
      endcase
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rs_gf_mul.sv
module rs_gf_mul #(
  parameter int              W           = 4,
  parameter logic [W:0]      WIDE_POLY   = 5'b10011,
  parameter logic [W-1:0]    NARROW_POLY = 4'b1011
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         narrow,
  output logic [W-1:0] p
);
  logic [W:0] acc;

  always_comb begin
    acc = '0;
    for (int i = W - 1; i >= 0; i--) begin
      acc = {acc[W-1:0], 1'b0};
      if (narrow) begin
        if (acc[W-1]) acc = acc ^ {1'b0, NARROW_POLY};
      end else if (acc[W]) begin
        acc = acc ^ WIDE_POLY;
      end
      if (b[i]) acc = acc ^ {1'b0, a};
    end
    p = acc[W-1:0];
  end
endmodule

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl
  import rs_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rs_mode_e mode,
  output logic     msg_phase,
  output logic     last_sym
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             active;

  always_comb begin
    active    = (mode != MODE_IDLE);
    msg_phase = active && (cnt_q < msg_len(mode));
    last_sym  = active && (cnt_q == code_len(mode) - CNT_W'(1));
    if (!active || last_sym) cnt_d = '0;
    else                     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: codeword position wraps straight to the first message slot
  a_r6_wrap_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    last_sym |=> (cnt_q == '0));
  // R1: position never runs past the selected code length
  a_r1_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_IDLE) |-> (cnt_q < code_len(mode)));
  // R8: parked mode returns the position to the start
  a_r8_idle_clears_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |=> (cnt_q == '0));
endmodule

// File: rtl/rs_remainder.sv
module rs_remainder
  import rs_enc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  rs_mode_e         mode,
  input  logic             msg_phase,
  input  logic             last_sym,
  input  logic [SYM_W-1:0] din,
  output logic [SYM_W-1:0] top_sym
);
  logic [SYM_W-1:0] r_q  [NSTAGE];
  logic [SYM_W-1:0] r_d  [NSTAGE];
  logic [SYM_W-1:0] coef [NSTAGE];
  logic [SYM_W-1:0] prod [NSTAGE];
  logic [NSTAGE-1:0] en;
  logic [SYM_W-1:0] fb;
  logic             long_code, narrow, active;

  always_comb begin
    active    = (mode != MODE_IDLE);
    long_code = (mode == MODE_15_9);
    narrow    = (mode == MODE_7_3);
    top_sym   = long_code ? r_q[NSTAGE-1] : r_q[NSHORT-1];
    fb        = msg_phase ? (din ^ top_sym) : '0;
    for (int i = 0; i < NSTAGE; i++) coef[i] = gen_coef(mode, i);
  end

  genvar g;
  generate
    for (g = 0; g < NSTAGE; g++) begin : g_tap
      rs_gf_mul #(.W(SYM_W)) u_mul (
        .a      (fb),
        .b      (coef[g]),
        .narrow (narrow),
        .p      (prod[g])
      );
    end
  endgenerate

  always_comb begin
    r_d[0] = active ? prod[0] : '0;
    for (int i = 1; i < NSTAGE; i++)
      r_d[i] = active ? (r_q[i-1] ^ prod[i]) : '0;
    for (int i = 0; i < NSTAGE; i++)
      en[i] = !active || (i < NSHORT) || long_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTAGE; i++) r_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSTAGE; i++)
        if (en[i]) r_q[i] <= r_d[i];
    end
  end

  // R6: no feedback enters the lowest stage while parity drains
  a_r6_drain_no_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !msg_phase) |=> (r_q[0] == '0));
  // R10: remainder empty once a codeword has completed
  a_r10_empty_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    last_sym |=> (r_q[0] == '0 && r_q[1] == '0 && r_q[2] == '0 &&
                  r_q[3] == '0 && r_q[4] == '0 && r_q[5] == '0));
  // R4: four-parity codes leave the two upper stages untouched at zero
  a_r4_upper_stages_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_7_3 || mode == MODE_15_11) |-> (r_q[4] == '0 && r_q[5] == '0));
endmodule

// File: rtl/rs_multi_encoder.sv
module rs_multi_encoder
  import rs_enc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] sym_out
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s_n;
  rs_mode_e               mode;
  logic [SYM_W-1:0]       din, top_sym;
  logic                   msg_phase, last_sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[SYNC_STAGES-1];

  always_comb begin
    mode = rs_mode_e'(sel);
    din  = (mode == MODE_7_3) ? {1'b0, sym_in[SYM_W-2:0]} : sym_in;
  end

  rs_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .mode      (mode),
    .msg_phase (msg_phase),
    .last_sym  (last_sym)
  );

  rs_remainder u_rem (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .mode      (mode),
    .msg_phase (msg_phase),
    .last_sym  (last_sym),
    .din       (din),
    .top_sym   (top_sym)
  );

  always_comb begin
    if (!rst_s_n || mode == MODE_IDLE) sym_out = '0;
    else if (msg_phase)                sym_out = din;
    else                               sym_out = top_sym;
  end

  // R8: parked mode drives nothing
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == MODE_IDLE) |-> (sym_out == '0));
  // R7: narrow field never shows the top bit
  a_r7_narrow_msb_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == MODE_7_3) |-> (sym_out[SYM_W-1] == 1'b0));
endmodule

// File: tb/tb_rs_multi_encoder.sv
module tb_rs_multi_encoder;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic [3:0] sym_in;
  logic [3:0] sym_out;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  rs_multi_encoder dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sym_in(sym_in), .sym_out(sym_out)
  );

  always #5 clk = ~clk;

  // Known codewords: {sel, symbols first-to-last left aligned in 60 bits}
  localparam logic [61:0] VEC [3] = '{
    {2'b01, 28'h0122313, 32'h0},
    {2'b10, 60'h0123456789ACE83},
    {2'b11, 60'h012345678BC0578}
  };

  function automatic int wlen(logic [1:0] s);
    return (s == 2'b01) ? 7 : 15;
  endfunction
  function automatic int mlen(logic [1:0] s);
    return (s == 2'b01) ? 3 : (s == 2'b10) ? 11 : 9;
  endfunction

  function automatic logic [3:0] bmul(logic [3:0] a, logic [3:0] b, bit nar);
    logic [7:0] p;
    p = '0;
    for (int i = 0; i < 4; i++) if (b[i]) p = p ^ ({4'b0, a} << i);
    if (nar) begin
      for (int d = 6; d >= 3; d--) if (p[d]) p = p ^ (8'b0000_1011 << (d - 3));
    end else begin
      for (int d = 6; d >= 4; d--) if (p[d]) p = p ^ (8'b0001_0011 << (d - 4));
    end
    return p[3:0];
  endfunction

  // Generator polynomial from the requirements, index 0 = constant term.
  function automatic logic [3:0] bgen(logic [1:0] s, int j);
    logic [3:0] g7 [5]  = '{4'h3, 4'h2, 4'h1, 4'h3, 4'h1};
    logic [3:0] g11 [5] = '{4'h7, 4'h8, 4'hC, 4'hD, 4'h1};
    logic [3:0] g9 [7]  = '{4'hC, 4'hA, 4'hC, 4'h3, 4'h9, 4'h7, 4'h1};
    if (s == 2'b01) return g7[j];
    if (s == 2'b10) return g11[j];
    return g9[j];
  endfunction

  // Long division of m(x) x^(n-k) by g(x); parity left aligned, high first.
  function automatic logic [23:0] model_par(logic [1:0] s, logic [59:0] msg);
    logic [3:0] p [15];
    logic [23:0] r;
    int n, k, np;
    logic [3:0] c;
    n = wlen(s); k = mlen(s); np = n - k;
    for (int i = 0; i < 15; i++) p[i] = '0;
    for (int i = 0; i < k; i++) p[n-1-i] = msg[59-4*i -: 4];
    for (int d = n - 1; d >= np; d--) begin
      c = p[d];
      for (int j = 0; j <= np; j++)
        p[d-np+j] = p[d-np+j] ^ bmul(c, bgen(s, j), s == 2'b01);
    end
    r = '0;
    for (int j = 0; j < np; j++) r[23-4*j -: 4] = p[np-1-j];
    return r;
  endfunction

  task automatic chk(logic [3:0] act, logic [3:0] exp, string rq, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  // Drives one whole codeword from the next falling edge; parity cycles use in=F.
  task automatic run_word(logic [1:0] s, logic [59:0] msg, logic [23:0] par,
                          string rq);
    int n, k;
    logic [3:0] m;
    n = wlen(s); k = mlen(s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel = s;
      if (i < k) begin
        m = msg[59-4*i -: 4];
        sym_in = m;
        #1;
        chk(sym_out, (s == 2'b01) ? {1'b0, m[2:0]} : m, "R2",
            $sformatf("message slot %0d", i));
      end else begin
        sym_in = 4'hF;
        #1;
        chk(sym_out, par[23-4*(i-k) -: 4], rq, $sformatf("parity slot %0d", i - k));
      end
    end
  endtask

  function automatic logic [59:0] masked(logic [1:0] s, logic [59:0] msg);
    logic [59:0] r;
    r = msg;
    if (s == 2'b01) for (int i = 0; i < 15; i++) r[59-4*i] = 1'b0;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [59:0] msg;
    logic [23:0] par;
    logic [1:0]  s;
    rst_n = 1'b0; sel = 2'b10; sym_in = 4'h9;
    repeat (3) @(negedge clk);
    #1 chk(sym_out, 4'h0, "R9", "output held in reset");
    sel = 2'b00;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: known vectors R3, R4, R5 (also R1 lengths)
    for (int v = 0; v < 3; v++) begin
      s = VEC[v][61:60];
      msg = VEC[v][59:0];
      par = '0;
      for (int j = 0; j < wlen(s) - mlen(s); j++)
        par[23-4*j -: 4] = msg[59-4*(mlen(s)+j) -: 4];
      chk(model_par(s, msg)[23:20], par[23:20], "R1", "bench model agrees with table");
      run_word(s, msg, par, (s == 2'b01) ? "R3" : (s == 2'b10) ? "R4" : "R5");
    end

    // Back-to-back random codewords per mode: R6, R10, R7
    for (int md = 1; md < 4; md++) begin
      s = 2'(md);
      for (int w = 0; w < 5; w++) begin
        for (int i = 0; i < 15; i++)
          msg[59-4*i -: 4] = (s == 2'b01) ? (4'h8 | 4'($urandom_range(0, 15)))
                                          : 4'($urandom_range(0, 15));
        par = model_par(s, masked(s, msg));
        run_word(s, msg, par, (s == 2'b01) ? "R7" : "R6");
      end
    end
    @(negedge clk); sel = 2'b00;

    // R8: park mid-word, output zero, then a fresh known codeword
    run_word(2'b10, 60'h0123456789ACE83, 24'hC_E_8_3_0_0, "R8");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sel = 2'b10; sym_in = 4'(i + 7);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sel = 2'b00; sym_in = 4'h7;
      #1 chk(sym_out, 4'h0, "R8", "parked output");
    end
    run_word(2'b10, VEC[1][59:0], 24'hCE8300, "R8");

    // R9: reset mid-word, synchronous release, then a known codeword
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); sel = 2'b11; sym_in = 4'(15 - i);
    end
    @(negedge clk); sym_in = 4'h5;
    #2 rst_n = 1'b0;
    #1 chk(sym_out, 4'h0, "R9", "output cleared by async reset");
    @(negedge clk); rst_n = 1'b1; sym_in = 4'h5;
    @(negedge clk); #1 chk(sym_out, 4'h0, "R9", "still in reset after one edge");
    run_word(2'b11, VEC[2][59:0], 24'hBC0578, "R9");
    @(negedge clk); sel = 2'b00;
    #1 chk(sym_out, 4'h0, "R8", "parked after final word");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule